// File: doc/BRIEF.md
# Dual-Port Memory with Cross-Port Mailbox Interrupts

This block is a synchronous memory with two fully independent ports, called left and right. Each port has its own enable, write strobe, output enable, address and data. In the same clock cycle, either port can read or write any word. The default geometry is kept small, with `AW` = 10 and `DW` = 9. The full-size part, 128K words of 9 bits, is built with `AW` = 17.

The two highest addresses can also serve as mailboxes. The top address minus one is the left port's mailbox. The top address is the right port's mailbox. When the peer port writes to a port's mailbox, that port's interrupt flag is raised. The owning port lowers its flag again by touching its own mailbox with enable and output enable both high. The mailbox words themselves hold normal data.

When the `mbox_en` input is low, both mailbox locations behave as plain memory and neither flag can change. A typical use is one agent on each port: an agent leaves a message in the peer's mailbox, and the peer's interrupt line announces it.

Top module: `dpmb_top`

## Requirements
- R1: While `rst_n` is low and after its release, both `*_irq_n` outputs are 1 (flag clear) and both `*_rdata` outputs are 0.
- R2: A write happens when `en`=1 and `we`=1 on the rising edge. A read happens when `en`=1, `oe`=1 and `we`=0. The read word appears on `rdata` after that edge and stays there until the port's next read.
- R3: The two ports work independently in the same cycle, and each can reach every address.
- R4: If one port reads an address in the same cycle that the other port writes it, the reading port returns the old word.
- R5: A port with `en`=0 does nothing. Its memory words, its `rdata` and both flags stay unchanged.
- R6: When `mbox_en`=1, a right-port write to address 2^AW-2 sets the left flag, so `l_irq_n`=0 after that edge.
- R7: When `mbox_en`=1, the left port clears its flag with `en`=1 and `oe`=1 at address 2^AW-2, whatever the level of `we`. In the same way, the right port clears its flag at address 2^AW-1.
- R8: When `mbox_en`=1, a left-port write to address 2^AW-1 sets the right flag, so `r_irq_n`=0 after that edge.
- R9: If a flag is set and cleared in the same cycle, the set wins and the flag stays asserted.
- R10: The mailbox words store data and return it exactly like any other address.
- R11: When `mbox_en`=0, neither flag changes, and the mailbox addresses behave as plain memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous reset, active low |
| mbox_en | input | 1 | Enables the mailbox interrupts |
| l_en | input | 1 | Left port enable |
| l_we | input | 1 | Left port write strobe |
| l_oe | input | 1 | Left port output enable |
| l_addr | input | AW | Left port address |
| l_wdata | input | DW | Left port write data |
| l_rdata | output | DW | Left port read data (one-cycle latency) |
| l_irq_n | output | 1 | Left interrupt, active low |
| r_en | input | 1 | Right port enable |
| r_we | input | 1 | Right port write strobe |
| r_oe | input | 1 | Right port output enable |
| r_addr | input | AW | Right port address |
| r_wdata | input | DW | Right port write data |
| r_rdata | output | DW | Right port read data (one-cycle latency) |
| r_irq_n | output | 1 | Right interrupt, active low |

## Verification
The memory is first filled through both ports. After that, random traffic steers about half of all addresses onto the two mailboxes and one hot word. This produces frequent read/write overlaps between the ports and frequent set/clear races on the flags, which separates a read-before-write memory from a write-through one, and a set-priority flag from a clear-priority one. Directed sequences then cover the following cases:
- a clear issued with the write strobe high;
- a disabled port presenting a mailbox write;
- traffic with `mbox_en` low.

These sequences separate decoding that checks `en` and `mbox_en` from decoding that ignores them.

// File: rtl/dpmb_pkg.sv
package dpmb_pkg;
  localparam int PORTS = 2;
  localparam int LEFT  = 0;
  localparam int RIGHT = 1;

  // mailbox owned by a port: left owns top-1, right owns top
  function automatic int unsigned box_of(input int aw, input int side);
    return (32'(1) << aw) - ((side == LEFT) ? 32'd2 : 32'd1);
  endfunction

  function automatic logic is_write(input logic en, input logic we);
    return en & we;
  endfunction

  function automatic logic is_read(input logic en, input logic we, input logic oe);
    return en & oe & ~we;
  endfunction

  function automatic logic is_touch(input logic en, input logic oe);
    return en & oe;
  endfunction

  // set has priority over clear
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction
endpackage

// File: rtl/dpmb_port_dec.sv
module dpmb_port_dec
  import dpmb_pkg::*;
#(
  parameter int AW   = 10,
  parameter int SIDE = 0
) (
  input  logic          en,
  input  logic          we,
  input  logic          oe,
  input  logic [AW-1:0] addr,
  input  logic          mbox_en,
  output logic          wr,
  output logic          rd,
  output logic          clr_own,
  output logic          set_peer
);
  localparam int PEER = (SIDE == LEFT) ? RIGHT : LEFT;
  localparam logic [AW-1:0] OWN_BOX  = AW'(box_of(AW, SIDE));
  localparam logic [AW-1:0] PEER_BOX = AW'(box_of(AW, PEER));

  always_comb begin
    wr       = is_write(en, we);
    rd       = is_read(en, we, oe);
    clr_own  = mbox_en & is_touch(en, oe) & (addr == OWN_BOX);
    set_peer = mbox_en & wr & (addr == PEER_BOX);
  end
endmodule

// File: rtl/dpmb_store.sv
module dpmb_store
  import dpmb_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 9
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [PORTS-1:0]           wr,
  input  logic [PORTS-1:0]           rd,
  input  logic [PORTS-1:0][AW-1:0]   addr,
  input  logic [PORTS-1:0][DW-1:0]   wdata,
  output logic [PORTS-1:0][DW-1:0]   rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr[LEFT])  mem[addr[LEFT]]  <= wdata[LEFT];
    if (wr[RIGHT]) mem[addr[RIGHT]] <= wdata[RIGHT];
  end

  // nonblocking update: a read in the cycle of a write sees the old word
  for (genvar p = 0; p < PORTS; p++) begin : g_rd
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata[p] <= '0;
      else if (rd[p]) rdata[p] <= mem[addr[p]];
    end
  end
endmodule

// File: rtl/dpmb_flag.sv
module dpmb_flag
  import dpmb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq_n
);
  logic flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_next(flag, set, clr);
  end

  assign irq_n = ~flag;
endmodule

// File: rtl/dpmb_top.sv
module dpmb_top
  import dpmb_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mbox_en,
  input  logic          l_en,
  input  logic          l_we,
  input  logic          l_oe,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_irq_n,
  input  logic          r_en,
  input  logic          r_we,
  input  logic          r_oe,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_irq_n
);
  logic [PORTS-1:0]         p_en, p_we, p_oe;
  logic [PORTS-1:0][AW-1:0] p_addr;
  logic [PORTS-1:0][DW-1:0] p_wdata, p_rdata;
  logic [PORTS-1:0]         p_wr, p_rd, p_clr, p_setpeer;
  // named events per flag owner, observed by the checker
  logic [PORTS-1:0]         irq_set, irq_clr;
  logic [PORTS-1:0]         irq_n_vec;

  assign p_en    = {r_en, l_en};
  assign p_we    = {r_we, l_we};
  assign p_oe    = {r_oe, l_oe};
  assign p_addr  = {r_addr, l_addr};
  assign p_wdata = {r_wdata, l_wdata};

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    dpmb_port_dec #(.AW(AW), .SIDE(p)) u_dec (
      .en       (p_en[p]),
      .we       (p_we[p]),
      .oe       (p_oe[p]),
      .addr     (p_addr[p]),
      .mbox_en  (mbox_en),
      .wr       (p_wr[p]),
      .rd       (p_rd[p]),
      .clr_own  (p_clr[p]),
      .set_peer (p_setpeer[p])
    );

    assign irq_set[p] = p_setpeer[PORTS-1-p];
    assign irq_clr[p] = p_clr[p];

    dpmb_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (irq_set[p]),
      .clr   (irq_clr[p]),
      .irq_n (irq_n_vec[p])
    );
  end

  dpmb_store #(.AW(AW), .DW(DW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (p_wr),
    .rd    (p_rd),
    .addr  (p_addr),
    .wdata (p_wdata),
    .rdata (p_rdata)
  );

  assign l_rdata = p_rdata[LEFT];
  assign r_rdata = p_rdata[RIGHT];
  assign l_irq_n = irq_n_vec[LEFT];
  assign r_irq_n = irq_n_vec[RIGHT];
endmodule

// File: rtl/dpmb_chk.sv
module dpmb_chk #(
  parameter int AW = 10,
  parameter int DW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mbox_en,
  input logic          l_en,
  input logic          l_we,
  input logic          l_oe,
  input logic [AW-1:0] l_addr,
  input logic [DW-1:0] l_rdata,
  input logic          l_irq_n,
  input logic          r_en,
  input logic          r_we,
  input logic          r_oe,
  input logic [AW-1:0] r_addr,
  input logic [DW-1:0] r_rdata,
  input logic          r_irq_n,
  input logic [1:0]    irq_set,
  input logic [1:0]    irq_clr
);
  localparam logic [AW-1:0] BOX_L = {{(AW-1){1'b1}}, 1'b0};
  localparam logic [AW-1:0] BOX_R = {AW{1'b1}};

  assert_left_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_en && r_en && r_we && r_addr == BOX_L) |=> !l_irq_n);

  assert_right_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_en && l_en && l_we && l_addr == BOX_R) |=> !r_irq_n);

  assert_left_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_en && l_en && l_oe && l_addr == BOX_L && !(r_en && r_we && r_addr == BOX_L))
    |=> l_irq_n);

  assert_right_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mbox_en && r_en && r_oe && r_addr == BOX_R && !(l_en && l_we && l_addr == BOX_R))
    |=> r_irq_n);

  assert_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !mbox_en |=> ($stable(l_irq_n) && $stable(r_irq_n)));

  assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_set == 2'b00 && irq_clr == 2'b00) |=> ($stable(l_irq_n) && $stable(r_irq_n)));

  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_en && l_oe && !l_we) |=> $stable(l_rdata));

  assert_r_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(r_en && r_oe && !r_we) |=> $stable(r_rdata));
endmodule

bind dpmb_top dpmb_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mbox_en(mbox_en),
  .l_en(l_en), .l_we(l_we), .l_oe(l_oe), .l_addr(l_addr), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
  .r_en(r_en), .r_we(r_we), .r_oe(r_oe), .r_addr(r_addr), .r_rdata(r_rdata), .r_irq_n(r_irq_n),
  .irq_set(irq_set), .irq_clr(irq_clr)
);

// File: tb/dpmb_top_tb.sv
module dpmb_top_tb;
  localparam int AW = 10;
  localparam int DW = 9;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] BOX_L = AW'(DEPTH - 2);
  localparam logic [AW-1:0] BOX_R = AW'(DEPTH - 1);

  logic clk = 0;
  logic rst_n = 0;
  logic mbox_en = 0;
  logic l_en = 0, l_we = 0, l_oe = 0, r_en = 0, r_we = 0, r_oe = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic [DW-1:0] l_wdata = '0, r_wdata = '0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_irq_n, r_irq_n;

  always #2 clk = ~clk;

  dpmb_top #(.AW(AW), .DW(DW)) u_dut (.*);

  int total = 0, bad = 0;
  bit finished = 0;

  logic [DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0] exp_l = '0, exp_r = '0;
  bit flag_l = 0, flag_r = 0;

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit le, input bit lw, input bit lo, input int la, input int ld,
                       input bit re, input bit rw, input bit ro, input int ra, input int rd);
    l_en = le; l_we = lw; l_oe = lo; l_addr = AW'(la); l_wdata = DW'(ld);
    r_en = re; r_we = rw; r_oe = ro; r_addr = AW'(ra); r_wdata = DW'(rd);
  endtask

  // advance one cycle: update model from the requirements, then compare
  task automatic cycle(input string tag);
    bit lwr, lrd, rwr, rrd, setl, clrl, setr, clrr;
    lwr = l_en && l_we;  lrd = l_en && l_oe && !l_we;
    rwr = r_en && r_we;  rrd = r_en && r_oe && !r_we;
    setl = mbox_en && rwr && r_addr == BOX_L;
    clrl = mbox_en && l_en && l_oe && l_addr == BOX_L;
    setr = mbox_en && lwr && l_addr == BOX_R;
    clrr = mbox_en && r_en && r_oe && r_addr == BOX_R;
    if (lrd) exp_l = ref_mem[l_addr];
    if (rrd) exp_r = ref_mem[r_addr];
    if (lwr) ref_mem[l_addr] = l_wdata;
    if (rwr) ref_mem[r_addr] = r_wdata;
    flag_l = setl ? 1'b1 : (clrl ? 1'b0 : flag_l);
    flag_r = setr ? 1'b1 : (clrr ? 1'b0 : flag_r);
    @(posedge clk);
    @(negedge clk);
    check({tag, " l_rdata"}, l_rdata, exp_l);
    check({tag, " r_rdata"}, r_rdata, exp_r);
    check({tag, " l_irq_n"}, DW'(l_irq_n), DW'(!flag_l));
    check({tag, " r_irq_n"}, DW'(r_irq_n), DW'(!flag_r));
  endtask

  function automatic int pick_addr();
    int k = int'($urandom % 8);
    if (k < 2) return int'(BOX_L);
    if (k < 4) return int'(BOX_R);
    if (k == 4) return 5;
    return int'($urandom % DEPTH);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    check("R1 l_irq_n in reset", DW'(l_irq_n), DW'(1));
    check("R1 r_rdata in reset", r_rdata, '0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 l_irq_n after reset", DW'(l_irq_n), DW'(1));
    check("R1 r_irq_n after reset", DW'(r_irq_n), DW'(1));
    check("R1 l_rdata after reset", l_rdata, '0);

    // preload through both ports, mailboxes off (R3)
    for (int a = 0; a < DEPTH; a += 2) begin
      drive(1, 1, 0, a, a ^ 9'h0AA, 1, 1, 0, a + 1, (a + 1) ^ 9'h155);
      cycle("R3 preload");
    end
    mbox_en = 1;

    // R4: right reads the word left writes this cycle
    drive(1, 1, 0, 7, 9'h1F0, 1, 0, 1, 7, 0);
    cycle("R4 read-old");
    check("R4 r_rdata old", r_rdata, DW'(7 ^ 9'h155));

    // R6: right writes left mailbox
    drive(0, 0, 0, 0, 0, 1, 1, 0, int'(BOX_L), 9'h1A5);
    cycle("R6 set");
    check("R6 l_irq_n low", DW'(l_irq_n), DW'(0));

    // R9: set and clear together
    drive(1, 0, 1, int'(BOX_L), 0, 1, 1, 0, int'(BOX_L), 9'h0C3);
    cycle("R9 race");
    check("R9 l_irq_n stays low", DW'(l_irq_n), DW'(0));

    // R7: clear with we high
    drive(1, 1, 1, int'(BOX_L), 9'h155, 0, 0, 0, 0, 0);
    cycle("R7 clear on write");
    check("R7 l_irq_n high", DW'(l_irq_n), DW'(1));

    // R10: mailbox content readable
    drive(1, 0, 1, int'(BOX_L), 0, 0, 0, 0, 0, 0);
    cycle("R10 read box");
    check("R10 l_rdata box", l_rdata, 9'h155);

    // R8: left writes right mailbox, right reads to clear
    drive(1, 1, 0, int'(BOX_R), 9'h03C, 0, 0, 0, 0, 0);
    cycle("R8 set");
    check("R8 r_irq_n low", DW'(r_irq_n), DW'(0));
    drive(0, 0, 0, 0, 0, 1, 0, 1, int'(BOX_R), 0);
    cycle("R8 clear");
    check("R8 r_irq_n high", DW'(r_irq_n), DW'(1));
    check("R10 r_rdata box", r_rdata, 9'h03C);

    // R5: disabled right port presents a mailbox write
    drive(0, 0, 0, 0, 0, 0, 1, 1, int'(BOX_L), 9'h0FF);
    cycle("R5 idle port");
    check("R5 l_irq_n unchanged", DW'(l_irq_n), DW'(1));
    drive(1, 0, 1, int'(BOX_L), 0, 0, 0, 0, 0, 0);
    cycle("R5 word kept");
    check("R5 box word kept", l_rdata, 9'h155);

    // R11: mailboxes off
    mbox_en = 0;
    drive(0, 0, 0, 0, 0, 1, 1, 0, int'(BOX_L), 9'h111);
    cycle("R11 plain write");
    check("R11 l_irq_n unchanged", DW'(l_irq_n), DW'(1));
    drive(1, 0, 1, int'(BOX_L), 0, 0, 0, 0, 0, 0);
    cycle("R11 plain read");
    check("R11 l_rdata", l_rdata, 9'h111);
    mbox_en = 1;

    // constrained random traffic (R2 R3 R4 R9)
    for (int i = 0; i < 4000; i++) begin
      int la, ra;
      bit le, lw, lo, re, rw, ro;
      la = pick_addr(); ra = pick_addr();
      le = ($urandom % 4) != 0; lw = $urandom % 2; lo = $urandom % 2;
      re = ($urandom % 4) != 0; rw = $urandom % 2; ro = $urandom % 2;
      if (le && lw && re && rw && la == ra) rw = 0;
      if (i % 500 == 499) mbox_en = !mbox_en;
      drive(le, lw, lo, la, int'($urandom % 512), re, rw, ro, ra, int'($urandom % 512));
      cycle("R2 random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule